// File: doc/BRIEF.md
# Sequenced Market-Feed Header Stripper with Gap Detection

This block is a byte-wide streaming stage placed after UDP header removal in a market-data receive path. Each incoming packet opens with a 20-byte header: a 10-byte session tag, an 8-byte big-endian number for the first message, and a 2-byte big-endian message count. The block consumes that header and hands only the message block that follows to the next stage. Both stream edges use valid/ready handshakes. During the header the block always accepts bytes and drives nothing downstream. Past the header, the input ready follows the output ready in the same cycle, so back-pressure passes straight through without buffering.

Across packets the block keeps the number it expects the next packet to start with: the previous packet's first number plus its message count, modulo 2^64. When a packet opens with any other number, a sticky gap flag rises. A system can use that flag as an interrupt or as a recovery trigger. The number and count of the most recent complete header are presented as side outputs. The session tag is not inspected.

Top module: `mold_gap_detector`

## Requirements
- R1: After reset, gap_error, pkt_seq and pkt_count are 0, and out_valid is 0 while no packet body is in flight.
- R2: The first 20 accepted bytes of each packet are header bytes. in_ready is 1 for all of them and none appears on the output. Bytes 10..17 are the number, most significant first, and bytes 18..19 are the count, most significant first.
- R3: Each byte after the header leaves unchanged on out_data, with out_last equal to in_last. In the same cycle out_valid equals in_valid and in_ready equals out_ready.
- R4: pkt_seq and pkt_count take the values of a header in the cycle after its byte 19 is accepted. They hold until the next complete header.
- R5: The first complete header after reset only sets the expected number. It never raises gap_error.
- R6: When byte 17 is accepted and its number differs from the expected one, gap_error is 1 from the next cycle. A matching number leaves gap_error unchanged.
- R7: Every complete header, including one that mismatched, sets the expected number to its number plus its count, modulo 2^64.
- R8: gap_error stays 1 until reset or until a cycle with gap_clear high. If a new mismatch and gap_clear fall in the same cycle, gap_error stays 1.
- R9: A packet whose last byte arrives before byte 19 is discarded. Nothing is forwarded, pkt_seq, pkt_count and the expected number keep their values, and the next byte starts a new header.
- R10: The session bytes 0..9 have no effect on any output.
- R11: A packet of exactly 20 bytes counts as a complete header and forwards nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_last | input | 1 | Final byte of the packet |
| in_ready | output | 1 | Block accepts the byte |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | 8 | Downstream byte |
| out_last | output | 1 | Final byte of the packet |
| out_ready | input | 1 | Downstream accepts the byte |
| gap_clear | input | 1 | One-cycle clear of the gap flag |
| gap_error | output | 1 | Sticky sequence discontinuity flag |
| pkt_seq | output | 64 | First message number of the last complete header |
| pkt_count | output | 16 | Message count of the last complete header |

## Verification
A header byte counter that is off by one either leaks a header byte downstream or swallows the first body byte. The output comparison catches this on the first packet with a body. A wrong expected number shows as a gap_error edge one cycle after byte 17 of the following packet, or as a missing one. A broken discard of short packets shows up on the next packet, whose header is then misaligned or compared against a stale expectation. Every packet therefore checks gap_error at byte 17 and checks the side outputs right after byte 19.

// File: rtl/mold_gap_pkg.sv
package mold_gap_pkg;
  typedef enum logic {
    ST_HDR = 1'b0,
    ST_FWD = 1'b1
  } mold_state_e;
endpackage

// File: rtl/mold_hdr_parse.sv
module mold_hdr_parse
  import mold_gap_pkg::*;
#(
  parameter int SESS_BYTES = 10,
  parameter int SEQ_BYTES  = 8,
  parameter int CNT_BYTES  = 2,
  localparam int SEQ_W     = 8 * SEQ_BYTES,
  localparam int CNT_W     = 8 * CNT_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output mold_state_e      state,
  output logic             seq_done,
  output logic [SEQ_W-1:0] seq_now,
  output logic [SEQ_W-1:0] seq_held,
  output logic             hdr_done,
  output logic [CNT_W-1:0] cnt_now
);
  localparam int HDR_BYTES = SESS_BYTES + SEQ_BYTES + CNT_BYTES;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);
  localparam int SEQ_LAST  = SESS_BYTES + SEQ_BYTES - 1;
  localparam int HDR_LAST  = HDR_BYTES - 1;

  logic [IDX_W-1:0] idx;
  logic [SEQ_W-1:0] seq_sh;
  logic [CNT_W-1:0] cnt_sh;
  logic             in_hdr, in_seq, in_cnt;

  assign in_hdr  = (state == ST_HDR);
  assign in_seq  = (idx >= IDX_W'(SESS_BYTES)) && (idx <= IDX_W'(SEQ_LAST));
  assign in_cnt  = (idx > IDX_W'(SEQ_LAST));
  assign seq_now = (seq_sh << 8) | SEQ_W'(in_data);
  assign cnt_now = (cnt_sh << 8) | CNT_W'(in_data);
  assign seq_held = seq_sh;
  assign seq_done = beat && in_hdr && (idx == IDX_W'(SEQ_LAST));
  assign hdr_done = beat && in_hdr && (idx == IDX_W'(HDR_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HDR;
      idx    <= '0;
      seq_sh <= '0;
      cnt_sh <= '0;
    end else if (beat) begin
      if (in_hdr) begin
        if (in_seq) seq_sh <= seq_now;
        if (in_cnt) cnt_sh <= cnt_now;
        if (in_last) begin
          idx <= '0;                      // short or header-only packet ends here
        end else if (idx == IDX_W'(HDR_LAST)) begin
          idx   <= '0;
          state <= ST_FWD;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (in_last) begin
        state <= ST_HDR;
      end
    end
  end

  // R2: the byte index never runs past the header
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(HDR_LAST));

  // R2: body forwarding starts only after the last header byte
  p_fwd_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWD && $past(state) == ST_HDR) |-> $past(idx == IDX_W'(HDR_LAST)));
endmodule

// File: rtl/mold_seq_track.sv
module mold_seq_track #(
  parameter int SEQ_W = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_done,
  input  logic [SEQ_W-1:0] seq_now,
  input  logic [SEQ_W-1:0] seq_held,
  input  logic             hdr_done,
  input  logic [CNT_W-1:0] cnt_now,
  input  logic             gap_clear,
  output logic             gap_error,
  output logic [SEQ_W-1:0] pkt_seq,
  output logic [CNT_W-1:0] pkt_count
);
  logic [SEQ_W-1:0] expected;
  logic             primed;
  logic             mismatch;

  assign mismatch = seq_done && primed && (seq_now != expected);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expected  <= '0;
      primed    <= 1'b0;
      gap_error <= 1'b0;
      pkt_seq   <= '0;
      pkt_count <= '0;
    end else begin
      if (hdr_done) begin
        expected  <= seq_held + SEQ_W'(cnt_now);
        primed    <= 1'b1;
        pkt_seq   <= seq_held;
        pkt_count <= cnt_now;
      end
      if (mismatch)       gap_error <= 1'b1;   // set wins over clear
      else if (gap_clear) gap_error <= 1'b0;
    end
  end

  // R8: the flag only drops on a clear
  p_gap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_error && !gap_clear) |=> gap_error);

  // R5: no flag before the first complete header
  p_first_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !gap_error);

  // R4: side outputs hold between complete headers
  p_side_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_done |=> ($stable(pkt_seq) && $stable(pkt_count)));
endmodule

// File: rtl/mold_fwd_gate.sv
module mold_fwd_gate
  import mold_gap_pkg::*;
(
  input  mold_state_e state,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        out_ready,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last
);
  always_comb begin
    in_ready  = 1'b1;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    if (state == ST_FWD) begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
      out_last  = in_last;
    end
  end
endmodule

// File: rtl/mold_gap_detector.sv
module mold_gap_detector
  import mold_gap_pkg::*;
#(
  parameter int SESS_BYTES = 10,
  parameter int SEQ_BYTES  = 8,
  parameter int CNT_BYTES  = 2,
  localparam int SEQ_W     = 8 * SEQ_BYTES,
  localparam int CNT_W     = 8 * CNT_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready,
  input  logic             gap_clear,
  output logic             gap_error,
  output logic [SEQ_W-1:0] pkt_seq,
  output logic [CNT_W-1:0] pkt_count
);
  mold_state_e      state;
  logic             beat, seq_done, hdr_done;
  logic [SEQ_W-1:0] seq_now, seq_held;
  logic [CNT_W-1:0] cnt_now;

  assign beat = in_valid && in_ready;

  mold_fwd_gate u_gate (
    .state(state), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  mold_hdr_parse #(.SESS_BYTES(SESS_BYTES), .SEQ_BYTES(SEQ_BYTES), .CNT_BYTES(CNT_BYTES)) u_parse (
    .clk(clk), .rst_n(rst_n), .beat(beat), .in_data(in_data), .in_last(in_last),
    .state(state), .seq_done(seq_done), .seq_now(seq_now), .seq_held(seq_held),
    .hdr_done(hdr_done), .cnt_now(cnt_now)
  );

  mold_seq_track #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .seq_now(seq_now),
    .seq_held(seq_held), .hdr_done(hdr_done), .cnt_now(cnt_now),
    .gap_clear(gap_clear), .gap_error(gap_error), .pkt_seq(pkt_seq),
    .pkt_count(pkt_count)
  );

  // R2: header bytes never reach the output
  p_hdr_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> (!out_valid && in_ready));

  // R3: back-pressure passes through while forwarding
  p_bp_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FWD) |-> (in_ready == out_ready && out_valid == in_valid));
endmodule

// File: tb/mold_gap_detector_tb.sv
module mold_gap_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, gap_clear = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_last, gap_error;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [63:0] pkt_seq;
  logic [15:0] pkt_count;

  int n_checks = 0, n_errors = 0;
  logic [8:0]  exp_q[$];
  logic        bp_on = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic [63:0] m_exp = '0;
  logic        m_primed = 1'b0, m_gap = 1'b0;
  logic [63:0] m_seq = '0;
  logic [15:0] m_cnt = '0;
  int          pkt_no = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mold_gap_detector u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .gap_clear(gap_clear), .gap_error(gap_error),
    .pkt_seq(pkt_seq), .pkt_count(pkt_count)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  // output monitor, samples mid-cycle
  always begin
    @(negedge clk); #2;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 header or stray byte forwarded", {55'd0, out_last, out_data}, 64'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({out_last, out_data} == e, "R3 forwarded byte/last", {55'd0, out_last, out_data}, {55'd0, e});
      end
    end
  end

  function automatic logic [7:0] hdr_byte(input int i, input logic [7:0] sess,
                                          input logic [63:0] seq, input logic [15:0] cnt);
    if (i < 10)      return sess + 8'(i * 3);
    else if (i < 18) return seq[8*(17-i) +: 8];
    else             return cnt[8*(19-i) +: 8];
  endfunction

  task automatic send_pkt(input logic [63:0] seq, input logic [15:0] cnt, input int len,
                          input logic [7:0] sess, input bit clr17, input string tag);
    logic [7:0] b;
    pkt_no++;
    for (int i = 20; i < len; i++)
      exp_q.push_back({i == len - 1, 8'((pkt_no * 31 + i * 7 + 3) & 255)});
    for (int i = 0; i < len; i++) begin
      b = (i < 20) ? hdr_byte(i, sess, seq, cnt) : 8'((pkt_no * 31 + i * 7 + 3) & 255);
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = (i == len - 1);
      gap_clear = clr17 && (i == 17);
      #1;
      if (i < 20) check(in_ready == 1'b1, "R2 header in_ready", {63'd0, in_ready}, 64'd1);
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #2;
      gap_clear = 1'b0;
      if (i == 17) begin
        if (clr17) m_gap = 1'b0;
        if (m_primed && seq != m_exp) m_gap = 1'b1;
        check(gap_error == m_gap, {"R6 R8 gap flag after byte 17: ", tag}, {63'd0, gap_error}, {63'd0, m_gap});
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    if (len >= 20) begin
      m_exp = seq + 64'(cnt); m_primed = 1'b1; m_seq = seq; m_cnt = cnt;
    end
    repeat (2) @(negedge clk);
    #3;
    check(pkt_seq == m_seq, {"R4 R9 pkt_seq: ", tag}, pkt_seq, m_seq);
    check(pkt_count == m_cnt, {"R4 R9 pkt_count: ", tag}, {48'd0, pkt_count}, {48'd0, m_cnt});
    check(gap_error == m_gap, {"R8 gap after packet: ", tag}, {63'd0, gap_error}, {63'd0, m_gap});
    check(exp_q.size() == 0, {"R3 R11 body drained: ", tag}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  task automatic pulse_clear();
    @(negedge clk); gap_clear = 1'b1;
    @(negedge clk); gap_clear = 1'b0; #1;
    m_gap = 1'b0;
    check(gap_error == 1'b0, "R8 idle clear", {63'd0, gap_error}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(gap_error == 0 && pkt_seq == 0 && pkt_count == 0 && out_valid == 0,
          "R1 reset state", {gap_error, pkt_seq[62:0]}, 64'd0);
    rst_n = 1'b1;

    // R5 first header primes without error
    send_pkt(64'd100, 16'd3, 25, 8'h41, 1'b0, "R5 first packet");

    // R3 R10 sweep body length, count, session and back-pressure
    for (int bp = 0; bp < 2; bp++)
      for (int pl = 0; pl < 8; pl++) begin
        bp_on = bp[0];
        send_pkt(m_exp, 16'(pl % 4), 20 + pl, 8'(pl * 17 + bp), 1'b0, "R10 sweep");
      end
    bp_on = 1'b1;
    send_pkt(m_exp, 16'd2, 40, 8'h77, 1'b0, "R3 long body backpressure");
    bp_on = 1'b0;

    // R6 forward gap, R7 resync, R8 sticky then clear
    send_pkt(m_exp + 64'd1, 16'd4, 22, 8'h10, 1'b0, "R6 forward gap");
    send_pkt(m_exp, 16'd1, 21, 8'h11, 1'b0, "R7 resync after gap");
    pulse_clear();
    send_pkt(m_exp, 16'd5, 23, 8'h12, 1'b0, "R7 consecutive after clear");

    // R6 backward gap, R8 set wins over same-cycle clear
    send_pkt(m_exp - 64'd5, 16'd2, 21, 8'h13, 1'b0, "R6 backward gap");
    send_pkt(m_exp + 64'd9, 16'd2, 21, 8'h14, 1'b1, "R8 set beats clear");
    send_pkt(m_exp, 16'd2, 21, 8'h15, 1'b1, "R8 clear at match");

    // R9 short packets of every truncated length
    for (int l = 1; l < 20; l++)
      send_pkt(m_exp, 16'd7, l, 8'(l), 1'b0, "R9 short packet");
    send_pkt(m_exp + 64'd3, 16'd7, 15, 8'h20, 1'b0, "R9 short before compare");
    send_pkt(m_exp, 16'd1, 24, 8'h21, 1'b0, "R9 expectation kept");

    // R11 header-only packet
    send_pkt(m_exp, 16'd6, 20, 8'h22, 1'b0, "R11 header only");
    send_pkt(m_exp, 16'd0, 21, 8'h23, 1'b0, "R11 following packet");

    // R7 modulo wrap of the expected number
    send_pkt(64'hFFFF_FFFF_FFFF_FFFE, 16'd3, 21, 8'h24, 1'b0, "R7 jump to top");
    pulse_clear();
    send_pkt(64'd1, 16'd1, 21, 8'h25, 1'b0, "R7 wrap match");

    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule